// File: doc/BRIEF.md
# Bit-manipulation execution unit

This unit is one execution lane of a 64-bit datapath. It handles three kinds of bit-level work, selected by a 3-bit opcode:

- **Bit-matrix transpose.** Each 64-bit doubleword is treated as an 8x8 bit matrix and transposed.
- **Integer min/max.** Signed and unsigned minimum and maximum, with a fixed result when the operands are equal.
- **Three-input lookup.** A bitwise operation in which each result bit is read from an 8-entry truth table. The table comes from an 8-bit immediate or from the low byte of the C operand.

Operands enter together with a valid strobe. The result is captured in a register and presented one clock later, with its own valid strobe.

Reset is an active-low asynchronous input. Inside the block it passes through a two-flop synchroniser, so it is applied at once but released on a clock edge. Decode, register files and predication belong to the surrounding pipeline.

Top module: `bmx_unit`

## Requirements
- R1: For opcode 0 (transpose), bit k of output byte j equals bit j of input byte k, for j and k in 0..7. Byte j occupies bits 8j+7..8j of the doubleword, and each doubleword of the operand is handled on its own.
- R2: Applying the transpose twice returns the original operand, and the transpose never changes the number of set bits.
- R3: Opcode 1 (signed min) returns A when A < B as two's-complement values and returns B otherwise, so equal operands give B.
- R4: Opcode 2 (signed max) returns A only when A > B as two's-complement values and returns B otherwise, so equal operands give B.
- R5: Opcodes 3 (unsigned min) and 4 (unsigned max) follow the rules of R3 and R4 with an unsigned comparison. Equal operands give B.
- R6: For opcode 5 (lookup), result bit i equals table[{A[i],B[i],C[i]}], with A as the index MSB. When `tbl_sel` is 0 the table is `imm`. Table 8'hF0 reproduces A, 8'hCC reproduces B and 8'hAA reproduces C.
- R7: When `tbl_sel` is 1 the lookup table is C[7:0], and `imm` has no effect.
- R8: Opcodes 6 and 7 give a zero result.
- R9: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `result` changes only in the cycle after an accepted operation and holds otherwise.
- R10: While reset is asserted, and after it is released until the first accepted operation, `out_valid` is 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronised internally on release |
| in_valid | input | 1 | Operands and opcode are valid this cycle |
| op | input | 3 | Operation select (0 transpose, 1 min, 2 max, 3 minu, 4 maxu, 5 lookup) |
| tbl_sel | input | 1 | Lookup table source: 0 immediate, 1 C[7:0] |
| imm | input | 8 | Immediate truth table |
| opa | input | DW | Operand A |
| opb | input | DW | Operand B |
| opc | input | DW | Operand C |
| out_valid | output | 1 | Result valid |
| result | output | DW | Registered result |

## Verification
The in-design checks assume that operands and opcode carry no unknown bits while the datapath is being sampled. They also assume that after reset the operands are set up away from the rising clock edge. The bench keeps within both: it drives every input to a defined value from time zero and changes inputs only on falling edges. With that holding, the checks cover several properties:
- min/max picks one of its two operands and is bounded correctly.
- The transpose preserves the number of set bits.
- The fixed lookup tables reproduce their operand.
- The valid and hold timing at the register follows R9.

// File: rtl/bmx_pkg.sv
package bmx_pkg;
  localparam int unsigned DWORD_BITS = 64;
  localparam int unsigned LANE_BITS  = 8;
  localparam int unsigned TBL_BITS   = 8;

  typedef enum logic [2:0] {
    OP_XPOSE = 3'd0,
    OP_MIN   = 3'd1,
    OP_MAX   = 3'd2,
    OP_MINU  = 3'd3,
    OP_MAXU  = 3'd4,
    OP_LUT   = 3'd5
  } bmx_op_e;
endpackage

// File: rtl/bmx_transpose.sv
module bmx_transpose #(
  parameter int unsigned DW = 64
) (
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  import bmx_pkg::*;
  localparam int unsigned NDW = DW / DWORD_BITS;

  for (genvar d = 0; d < NDW; d++) begin : g_dw
    for (genvar j = 0; j < LANE_BITS; j++) begin : g_row
      for (genvar k = 0; k < LANE_BITS; k++) begin : g_col
        assign dout[d*DWORD_BITS + j*LANE_BITS + k] = din[d*DWORD_BITS + k*LANE_BITS + j];
      end
    end
  end

  always_comb begin
    if (!$isunknown(din)) begin
      AST_XPOSE_POPCOUNT: assert ($countones(dout) == $countones(din)); // R2
    end
  end
endmodule

// File: rtl/bmx_minmax.sv
module bmx_minmax #(
  parameter int unsigned DW = 64
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          is_signed,
  input  logic          is_max,
  output logic [DW-1:0] y
);
  logic a_lt_b;
  logic a_gt_b;

  always_comb begin
    if (is_signed) begin
      a_lt_b = $signed(a) < $signed(b);
      a_gt_b = $signed(a) > $signed(b);
    end else begin
      a_lt_b = a < b;
      a_gt_b = a > b;
    end
    if (is_max) y = a_gt_b ? a : b;
    else        y = a_lt_b ? a : b;
  end

  always_comb begin
    if (!$isunknown({a, b, is_signed, is_max})) begin
      AST_MM_PICKS_OPERAND: assert (y == a || y == b); // R3
      if (is_signed && is_max) begin
        AST_MM_SMAX_BOUND: assert (!($signed(y) < $signed(a)) && !($signed(y) < $signed(b))); // R4
      end
      if (!is_signed && !is_max) begin
        AST_MM_UMIN_BOUND: assert (y <= a && y <= b); // R5
      end
    end
  end
endmodule

// File: rtl/bmx_ternlog.sv
module bmx_ternlog #(
  parameter int unsigned DW = 64
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [DW-1:0] c,
  input  logic [7:0]    tbl,
  output logic [DW-1:0] y
);
  for (genvar i = 0; i < DW; i++) begin : g_bit
    assign y[i] = tbl[{a[i], b[i], c[i]}];
  end

  always_comb begin
    if (!$isunknown({a, b, c, tbl})) begin
      if (tbl == 8'hF0) begin
        AST_LUT_PASS_A: assert (y == a); // R6
      end
      if (tbl == 8'hCC) begin
        AST_LUT_PASS_B: assert (y == b); // R6
      end
      if (tbl == 8'hAA) begin
        AST_LUT_PASS_C: assert (y == c); // R6
      end
    end
  end
endmodule

// File: rtl/bmx_unit.sv
module bmx_unit #(
  parameter int unsigned DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [2:0]    op,
  input  logic          tbl_sel,
  input  logic [7:0]    imm,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic [DW-1:0] opc,
  output logic          out_valid,
  output logic [DW-1:0] result
);
  import bmx_pkg::*;

  logic          rst_s1;
  logic          rst_q;
  logic [DW-1:0] xpose_y;
  logic [DW-1:0] mm_y;
  logic [DW-1:0] lut_y;
  logic [TBL_BITS-1:0] lut_tbl;
  logic          mm_signed;
  logic          mm_max;
  logic [DW-1:0] result_d;
  logic          valid_d;
  logic          res_en;

  // reset: asserted at once, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_q  <= rst_s1;
    end
  end

  assign mm_signed = (op == OP_MIN) || (op == OP_MAX);
  assign mm_max    = (op == OP_MAX) || (op == OP_MAXU);
  assign lut_tbl   = tbl_sel ? opc[TBL_BITS-1:0] : imm;

  bmx_transpose #(.DW(DW)) u_xpose (
    .din  (opa),
    .dout (xpose_y)
  );

  bmx_minmax #(.DW(DW)) u_minmax (
    .a         (opa),
    .b         (opb),
    .is_signed (mm_signed),
    .is_max    (mm_max),
    .y         (mm_y)
  );

  bmx_ternlog #(.DW(DW)) u_lut (
    .a   (opa),
    .b   (opb),
    .c   (opc),
    .tbl (lut_tbl),
    .y   (lut_y)
  );

  // next-state
  always_comb begin
    unique case (op)
      OP_XPOSE: result_d = xpose_y;
      OP_MIN, OP_MAX, OP_MINU, OP_MAXU: result_d = mm_y;
      OP_LUT:   result_d = lut_y;
      default:  result_d = '0;
    endcase
    valid_d = in_valid;
    res_en  = in_valid;
  end

  // registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= valid_d;
      if (res_en) result <= result_d;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_q)
    in_valid |=> out_valid); // R9
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_q)
    !in_valid |=> !out_valid); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_q)
    !in_valid |=> $stable(result)); // R9
  AST_BAD_OP_ZERO: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && op > 3'd5) |=> (result == '0)); // R8
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_q |-> (!out_valid && result == '0)); // R10
endmodule

// File: tb/tb_bmx_unit.sv
module tb_bmx_unit;
  localparam int DW = 64;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic [2:0]    op;
  logic          tbl_sel;
  logic [7:0]    imm;
  logic [DW-1:0] opa, opb, opc;
  logic          out_valid;
  logic [DW-1:0] result;

  int checks = 0;
  int errors = 0;

  bmx_unit #(.DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .tbl_sel(tbl_sel),
    .imm(imm), .opa(opa), .opb(opb), .opc(opc), .out_valid(out_valid), .result(result)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [63:0] ref_xpose(input logic [63:0] x);
    logic [63:0] r;
    for (int j = 0; j < 8; j++)
      for (int k = 0; k < 8; k++)
        r[j*8+k] = x[k*8+j];
    return r;
  endfunction

  function automatic logic [63:0] ref_lut(input logic [63:0] a, b, c, input logic [7:0] t);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) r[i] = t[{a[i], b[i], c[i]}];
    return r;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [2:0] o, input logic [63:0] a, b, c,
                     input logic [7:0] t, input logic s, output logic [63:0] r);
    @(negedge clk);
    op = o; opa = a; opb = b; opc = c; imm = t; tbl_sel = s; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 valid", {63'd0, out_valid}, 64'd1);
    r = result;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R10 valid in reset", {63'd0, out_valid}, 64'd0);
    chk("R10 result in reset", result, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 valid after release", {63'd0, out_valid}, 64'd0);
    chk("R10 result after release", result, 64'd0);
  endtask

  task automatic t_xpose();
    logic [63:0] r, r2;
    logic [63:0] pats [4] = '{64'h8040201008040201, 64'h00000000000000FF,
                              64'h0123456789ABCDEF, 64'hF0E1D2C3B4A59687};
    foreach (pats[n]) begin
      run(3'd0, pats[n], 64'h5555, 64'h0, 8'h00, 1'b0, r);
      chk("R1 transpose", r, ref_xpose(pats[n]));
      chk("R2 popcount", 64'($countones(r)), 64'($countones(pats[n])));
      run(3'd0, r, 64'h0, 64'h0, 8'h00, 1'b0, r2);
      chk("R2 involution", r2, pats[n]);
    end
    run(3'd0, 64'h00000000000000FF, 64'h0, 64'h0, 8'h00, 1'b0, r);
    chk("R1 low byte to column", r, 64'h0101010101010101);
  endtask

  task automatic t_minmax();
    logic [63:0] r;
    logic [63:0] neg1 = 64'hFFFFFFFFFFFFFFFF;
    run(3'd1, neg1, 64'd1, 64'h0, 8'h0, 1'b0, r); chk("R3 smin neg", r, neg1);
    run(3'd1, 64'd7, 64'd3, 64'h0, 8'h0, 1'b0, r); chk("R3 smin pos", r, 64'd3);
    run(3'd1, 64'h00A5, 64'h00A5, 64'h0, 8'h0, 1'b0, r); chk("R3 smin tie", r, 64'h00A5);
    run(3'd2, neg1, 64'd1, 64'h0, 8'h0, 1'b0, r); chk("R4 smax", r, 64'd1);
    run(3'd2, 64'h8000000000000000, 64'h7FFFFFFFFFFFFFFF, 64'h0, 8'h0, 1'b0, r);
    chk("R4 smax extremes", r, 64'h7FFFFFFFFFFFFFFF);
    run(3'd2, 64'd42, 64'd42, 64'h0, 8'h0, 1'b0, r); chk("R4 smax tie", r, 64'd42);
    run(3'd3, neg1, 64'd1, 64'h0, 8'h0, 1'b0, r); chk("R5 umin", r, 64'd1);
    run(3'd4, neg1, 64'd1, 64'h0, 8'h0, 1'b0, r); chk("R5 umax", r, neg1);
    run(3'd4, 64'd9, 64'd9, 64'h0, 8'h0, 1'b0, r); chk("R5 umax tie", r, 64'd9);
    run(3'd3, 64'd5, 64'd6, 64'h0, 8'h0, 1'b0, r); chk("R5 umin A", r, 64'd5);
  endtask

  task automatic t_lut();
    logic [63:0] r;
    logic [63:0] a = 64'hDEADBEEF01234567;
    logic [63:0] b = 64'h0F0F00FFCAFEF00D;
    logic [63:0] c = 64'h3333AAAA5A5A1234;
    run(3'd5, a, b, c, 8'hF0, 1'b0, r); chk("R6 table F0", r, a);
    run(3'd5, a, b, c, 8'hCC, 1'b0, r); chk("R6 table CC", r, b);
    run(3'd5, a, b, c, 8'h96, 1'b0, r); chk("R6 xor3", r, a ^ b ^ c);
    run(3'd5, a, b, c, 8'hE8, 1'b0, r); chk("R6 majority", r, ref_lut(a, b, c, 8'hE8));
    run(3'd5, a, b, {c[63:8], 8'hF0}, 8'h00, 1'b1, r);
    chk("R7 register table", r, ref_lut(a, b, {c[63:8], 8'hF0}, 8'hF0));
    run(3'd5, a, b, {c[63:8], 8'h3C}, 8'hFF, 1'b1, r);
    chk("R7 imm ignored", r, ref_lut(a, b, {c[63:8], 8'h3C}, 8'h3C));
  endtask

  task automatic t_badop();
    logic [63:0] r;
    run(3'd6, 64'h1234, 64'h5678, 64'h9ABC, 8'hFF, 1'b0, r); chk("R8 op6", r, 64'd0);
    run(3'd7, 64'hFFFF, 64'hFFFF, 64'hFFFF, 8'hFF, 1'b0, r); chk("R8 op7", r, 64'd0);
  endtask

  task automatic t_hold();
    logic [63:0] r;
    run(3'd4, 64'd100, 64'd50, 64'h0, 8'h0, 1'b0, r);
    chk("R9 captured", r, 64'd100);
    op = 3'd3; opa = 64'd1; opb = 64'd2;
    @(negedge clk);
    chk("R9 no valid", {63'd0, out_valid}, 64'd0);
    chk("R9 hold", result, 64'd100);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op = 3'd0; tbl_sel = 1'b0; imm = 8'h0;
    opa = '0; opb = '0; opc = '0;
    repeat (3) @(negedge clk);
    t_reset();
    t_xpose();
    t_minmax();
    t_lut();
    t_badop();
    t_hold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule